// File: doc/BRIEF.md
# Receive FIFO Overrun Controller

This block controls the receive-side character buffer of one asynchronous serial channel. A receive shift register, which is not part of this block, reports two events: the detection of a start bit, and the completion of a character together with its 8 data bits and 3 error flags. This block files completed characters into an 8-entry FIFO that a host drains one entry at a time. It shows the oldest entry and raises a ready flag while anything is stored.

When the FIFO is full, a newly completed character is not dropped. It stays parked in the shift register and moves into the FIFO as soon as a slot opens. If yet another character begins while one is parked, the parked character is thrown away, the FIFO is left as it was, and a sticky overrun flag is raised. An optional automatic flow-control output (active-low request-to-send) tells the far transmitter to pause while the buffer cannot take more.

Host commands turn the receiver on, turn it off (stop receiving but keep stored data readable), reset it (empty everything and stay off), and clear the overrun flag. Bit sampling, baud timing and register decode live elsewhere.

Top module: `rx_overrun_buf`

## Requirements
- R1: Characters leave the FIFO in arrival order. `rdData`/`rdStat` show the oldest entry: data in `rdData`, and flags in `rdStat` with bit 2 = parity error, bit 1 = framing error, bit 0 = break. Both read zero while the FIFO is empty. A `rdStrobe` pulse removes the shown entry.
- R2: `rxRdy` is high exactly when the FIFO holds at least one character, for every fill level from 0 to 8.
- R3: A character that completes while all 8 slots are used is parked and loses nothing. It enters the FIFO behind the existing entries as soon as a read frees a slot.
- R4: A start bit that arrives while a character is parked and the FIFO is full discards the parked character and leaves the FIFO unchanged. From the next cycle, `overrun` reads 1.
- R5: `overrun` stays 1 through reads until a clear-error command or a receiver reset command. The cycle after either one, it reads 0.
- R6: With `autoRtsEn` high, a start bit accepted while the FIFO is full drives `rtsN` high from the next cycle.
- R7: With `autoRtsEn` high, `rtsN` returns low by the second cycle after a read frees a FIFO slot.
- R8: With `autoRtsEn` low, `rtsN` stays low even when start bits arrive while the FIFO is full.
- R9: A disable command stops reception at once. A character being assembled is dropped, and later start bits and completions are ignored. Stored entries remain readable.
- R10: After an enable command, a character completion is accepted only if a start bit has been seen since the enable. A completion with no preceding start bit is ignored.
- R11: A reset command empties the FIFO, drops any parked character, clears `rxRdy`, `overrun`, `rdStat` and `rtsN`, and leaves the receiver off until an enable command.
- R12: After `rstN`, the FIFO is empty, `overrun` and `rtsN` are low, and the receiver ignores characters until an enable command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startBit | input | 1 | One-cycle strobe: start bit detected by the shift register |
| chrDone | input | 1 | One-cycle strobe: character assembled |
| chrData | input | 8 | Data of the assembled character |
| chrStat | input | 3 | Flags of the assembled character (parity, framing, break) |
| cmdEnable | input | 1 | Turn the receiver on |
| cmdDisable | input | 1 | Turn the receiver off, keep stored data |
| cmdReset | input | 1 | Receiver reset command |
| cmdClrErr | input | 1 | Clear the overrun flag |
| autoRtsEn | input | 1 | Enable automatic flow control on `rtsN` |
| rdStrobe | input | 1 | Host read: remove the oldest entry |
| rdData | output | 8 | Data of the oldest entry |
| rdStat | output | 3 | Flags of the oldest entry |
| rxRdy | output | 1 | FIFO not empty |
| overrun | output | 1 | Sticky overrun flag |
| rtsN | output | 1 | Request-to-send, active low |

## Verification
The bench sweeps every fill level from one to eight and reads each level back against arithmetic data patterns. A wrong pointer wrap or count would return the wrong byte or a stale ready flag. It fills the FIFO and parks a ninth character, which catches a design that drops that character or lets it overtake older entries. It then sends a tenth character, which catches a design that flags overrun late, disturbs the stored entries, or keeps the old parked byte instead of the newest one. It also checks that a completion is ignored after disable, and again after re-enable when no start bit was seen. Finally it checks that a reset command leaves the receiver off; a design that confused disable with reset, or re-armed itself, would accept characters there.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  // strobes the control sends to the datapath
  typedef struct packed {
    logic pushNew;   // write the incoming character into the FIFO
    logic pushHold;  // write the parked character into the FIFO
    logic loadHold;  // park the incoming character
    logic pop;       // remove the head entry
    logic flush;     // empty FIFO, realign pointers
  } bufStrb_t;
endpackage

// File: rtl/rx_buf_dpath.sv
module rx_buf_dpath
  import rxbuf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int STAT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrb_t          strb,
  input  logic [DATA_W-1:0] inData,
  input  logic [STAT_W-1:0] inStat,
  output logic [DATA_W-1:0] rdData,
  output logic [STAT_W-1:0] rdStat,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = DATA_W + STAT_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic [ENT_W-1:0] holdWord;
  logic [ENT_W-1:0] wrWord;
  logic [ENT_W-1:0] headWord;
  logic             doPush;

  assign doPush   = strb.pushNew | strb.pushHold;
  assign wrWord   = strb.pushHold ? holdWord : {inData, inStat};
  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign headWord = empty ? '0 : mem[rdPtr];
  assign rdData   = headWord[ENT_W-1:STAT_W];
  assign rdStat   = headWord[STAT_W-1:0];

  // parked character (the shift register's copy)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              holdWord <= '0;
    else if (strb.loadHold) holdWord <= {inData, inStat};
  end

  always_ff @(posedge clk) begin
    if (doPush && !strb.flush) mem[wrPtr] <= wrWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (strb.pop) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(doPush) - CNT_W'(strb.pop);
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    doPush |-> !full);
  // R1
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  // R3
  push_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.pushNew, strb.pushHold, strb.loadHold}));
  // R1
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> !empty);
endmodule

// File: rtl/rx_buf_ctrl.sv
module rx_buf_ctrl
  import rxbuf_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startBit,
  input  logic     chrDone,
  input  logic     cmdEnable,
  input  logic     cmdDisable,
  input  logic     cmdReset,
  input  logic     cmdClrErr,
  input  logic     autoRtsEn,
  input  logic     rdStrobe,
  input  logic     full,
  input  logic     empty,
  output bufStrb_t strb,
  output logic     overrun,
  output logic     rtsN
);
  logic rxOn;       // receiver enabled
  logic asmActive;  // start bit seen, character in assembly
  logic holdValid;  // a completed character is parked
  logic quiet, startAcc, chrAcc, moveHold, dropHold;

  assign quiet    = cmdReset | cmdDisable;
  assign startAcc = startBit && rxOn && !quiet;
  assign chrAcc   = chrDone && asmActive && !quiet;
  assign moveHold = holdValid && !full && !quiet;
  assign dropHold = startAcc && holdValid && full;

  always_comb begin
    strb          = '0;
    strb.flush    = cmdReset;
    strb.pop      = rdStrobe && !empty && !cmdReset;
    strb.pushNew  = chrAcc && !full;
    strb.loadHold = chrAcc && full;
    strb.pushHold = moveHold;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxOn      <= 1'b0;
      asmActive <= 1'b0;
      holdValid <= 1'b0;
    end else if (quiet) begin
      rxOn      <= 1'b0;
      asmActive <= 1'b0;
      holdValid <= 1'b0;
    end else begin
      if (cmdEnable) rxOn <= 1'b1;
      if (startAcc)    asmActive <= 1'b1;
      else if (chrAcc) asmActive <= 1'b0;
      if (strb.loadHold)          holdValid <= 1'b1;
      else if (moveHold || dropHold) holdValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          overrun <= 1'b0;
    else if (cmdReset)  overrun <= 1'b0;
    else if (dropHold)  overrun <= 1'b1;
    else if (cmdClrErr) overrun <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         rtsN <= 1'b0;
    else if (cmdReset || !autoRtsEn)   rtsN <= 1'b0;
    else if (startAcc && full)         rtsN <= 1'b1;
    else if (!full)                    rtsN <= 1'b0;
  end

  // R4
  ovr_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(startBit && holdValid && full));
  // R5
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !cmdClrErr && !cmdReset) |=> overrun);
  // R8
  rts_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !autoRtsEn |=> !rtsN);
  // R10
  no_hold_in_asm_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(holdValid && asmActive));
  // R9
  disable_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdDisable |=> (!asmActive && !holdValid));
endmodule

// File: rtl/rx_overrun_buf.sv
module rx_overrun_buf #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int STAT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startBit,
  input  logic              chrDone,
  input  logic [DATA_W-1:0] chrData,
  input  logic [STAT_W-1:0] chrStat,
  input  logic              cmdEnable,
  input  logic              cmdDisable,
  input  logic              cmdReset,
  input  logic              cmdClrErr,
  input  logic              autoRtsEn,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rdData,
  output logic [STAT_W-1:0] rdStat,
  output logic              rxRdy,
  output logic              overrun,
  output logic              rtsN
);
  rxbuf_pkg::bufStrb_t strb;
  logic full, empty;

  rx_buf_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startBit(startBit), .chrDone(chrDone),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .cmdReset(cmdReset),
    .cmdClrErr(cmdClrErr), .autoRtsEn(autoRtsEn), .rdStrobe(rdStrobe),
    .full(full), .empty(empty), .strb(strb), .overrun(overrun), .rtsN(rtsN)
  );

  rx_buf_dpath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .STAT_W(STAT_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(chrData), .inStat(chrStat),
    .rdData(rdData), .rdStat(rdStat), .full(full), .empty(empty)
  );

  assign rxRdy = !empty;
endmodule

// File: tb/rx_overrun_buf_test.sv
`timescale 1ns/1ps
module rx_overrun_buf_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startBit = 0, chrDone = 0, cmdEnable = 0, cmdDisable = 0;
  logic cmdReset = 0, cmdClrErr = 0, autoRtsEn = 0, rdStrobe = 0;
  logic [7:0] chrData = 0;
  logic [2:0] chrStat = 0;
  logic [7:0] rdData;
  logic [2:0] rdStat;
  logic rxRdy, overrun, rtsN;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rx_overrun_buf uut (
    .clk(clk), .rstN(rstN), .startBit(startBit), .chrDone(chrDone),
    .chrData(chrData), .chrStat(chrStat), .cmdEnable(cmdEnable),
    .cmdDisable(cmdDisable), .cmdReset(cmdReset), .cmdClrErr(cmdClrErr),
    .autoRtsEn(autoRtsEn), .rdStrobe(rdStrobe), .rdData(rdData),
    .rdStat(rdStat), .rxRdy(rxRdy), .overrun(overrun), .rtsN(rtsN)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic startPulse();
    startBit = 1; step(); startBit = 0;
  endtask

  task automatic donePulse(input logic [7:0] d, input logic [2:0] s);
    chrData = d; chrStat = s; chrDone = 1; step(); chrDone = 0;
  endtask

  task automatic sendChar(input logic [7:0] d, input logic [2:0] s);
    startPulse();
    donePulse(d, s);
    step();
  endtask

  task automatic readChk(input logic [7:0] d, input logic [2:0] s, input string req);
    chk(rxRdy == 1'b1, req, rxRdy, 1);
    chk(rdData == d, req, rdData, d);
    chk(rdStat == s, req, rdStat, s);
    rdStrobe = 1; step(); rdStrobe = 0;
    step();
  endtask

  task automatic cmd(input int which);
    case (which)
      0: cmdEnable = 1;
      1: cmdDisable = 1;
      2: cmdReset = 1;
      default: cmdClrErr = 1;
    endcase
    step();
    cmdEnable = 0; cmdDisable = 0; cmdReset = 0; cmdClrErr = 0;
  endtask

  function automatic logic [7:0] pat(input int n, input int i);
    return 8'((n * 37 + i * 11 + 5) & 255);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R12: reset state
    chk(rxRdy == 0, "R12 rxRdy", rxRdy, 0);
    chk(overrun == 0, "R12 overrun", overrun, 0);
    chk(rtsN == 0, "R12 rtsN", rtsN, 0);
    chk(rdData == 0 && rdStat == 0, "R1 empty head", rdData, 0);
    step(); rstN = 1; step();
    sendChar(8'hA5, 3'd1);
    chk(rxRdy == 0, "R12 off until enable", rxRdy, 0);
    cmd(0);

    // R1 R2: sweep every fill level
    for (int n = 1; n <= 8; n++) begin
      for (int i = 0; i < n; i++) sendChar(pat(n, i), 3'((n + i) % 8));
      chk(rxRdy == 1, "R2 filled", rxRdy, 1);
      for (int i = 0; i < n; i++) readChk(pat(n, i), 3'((n + i) % 8), "R1 order");
      chk(rxRdy == 0, "R2 drained", rxRdy, 0);
      chk(rdStat == 0, "R1 empty stat", rdStat, 0);
    end

    // R3 R6 R7: parked character with auto flow control
    autoRtsEn = 1;
    for (int k = 0; k < 8; k++) sendChar(8'h40 + 8'(k), 3'(k));
    chk(rtsN == 0, "R7 not yet", rtsN, 0);
    startPulse();
    chk(rtsN == 1, "R6 rts high", rtsN, 1);
    donePulse(8'h49, 3'd7); step();
    readChk(8'h40, 3'd0, "R3 head");
    chk(rtsN == 0, "R7 rts low", rtsN, 0);
    for (int k = 1; k < 8; k++) readChk(8'h40 + 8'(k), 3'(k), "R3 order");
    readChk(8'h49, 3'd7, "R3 parked char");
    chk(rxRdy == 0, "R3 nothing extra", rxRdy, 0);

    // R4 R5: overrun
    for (int k = 0; k < 8; k++) sendChar(8'h60 + 8'(k), 3'(k));
    sendChar(8'h70, 3'd2);
    chk(overrun == 0, "R4 parked only", overrun, 0);
    startPulse();
    chk(overrun == 1, "R4 overrun set", overrun, 1);
    donePulse(8'h71, 3'd5); step();
    for (int k = 0; k < 8; k++) readChk(8'h60 + 8'(k), 3'(k), "R4 fifo intact");
    readChk(8'h71, 3'd5, "R4 newest kept");
    chk(rxRdy == 0, "R4 old parked lost", rxRdy, 0);
    chk(overrun == 1, "R5 sticky", overrun, 1);
    cmd(3);
    chk(overrun == 0, "R5 cleared", overrun, 0);

    // R8: flow control off
    autoRtsEn = 0;
    for (int k = 0; k < 8; k++) sendChar(8'h80 + 8'(k), 3'd0);
    startPulse();
    chk(rtsN == 0, "R8 rts stays low", rtsN, 0);
    donePulse(8'h88, 3'd0); step();
    for (int k = 0; k < 9; k++) readChk(8'h80 + 8'(k), 3'd0, "R8 drain");

    // R9: disable
    sendChar(8'h21, 3'd4);
    startPulse();
    cmd(1);
    donePulse(8'h22, 3'd0); step();
    sendChar(8'h23, 3'd0);
    readChk(8'h21, 3'd4, "R9 stored readable");
    chk(rxRdy == 0, "R9 ignored chars", rxRdy, 0);

    // R10: re-enable needs a fresh start bit
    cmd(0);
    donePulse(8'h33, 3'd0); step();
    chk(rxRdy == 0, "R10 no start bit", rxRdy, 0);
    sendChar(8'h34, 3'd6);
    readChk(8'h34, 3'd6, "R10 accepted");

    // R11: reset command
    autoRtsEn = 1;
    for (int k = 0; k < 8; k++) sendChar(8'h90 + 8'(k), 3'd3);
    sendChar(8'h98, 3'd0);
    sendChar(8'h99, 3'd0);
    chk(overrun == 1 && rtsN == 1, "R11 pre state", {overrun, rtsN}, 3);
    cmd(2);
    chk(rxRdy == 0, "R11 rxRdy", rxRdy, 0);
    chk(rdStat == 0 && rdData == 0, "R11 head", rdStat, 0);
    chk(overrun == 0, "R11 overrun", overrun, 0);
    chk(rtsN == 0, "R11 rtsN", rtsN, 0);
    sendChar(8'h5A, 3'd0);
    chk(rxRdy == 0, "R11 stays off", rxRdy, 0);
    cmd(0);
    sendChar(8'h5B, 3'd1);
    readChk(8'h5B, 3'd1, "R11 after enable");
    chk(rxRdy == 0, "R11 parked dropped", rxRdy, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule